// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block is the modem-line corner of a UART. It keeps a five-bit control register that drives four modem output lines and selects a loopback test mode. It also produces an eight-bit status byte. The upper half of that byte shows the present level of the four modem input lines. The lower half holds change flags that stay set until software reads the status byte.

The input lines are asynchronous. Each one passes through a synchroniser before change detection. A change is detected by comparing the newest synchronised sample with the sample captured one clock earlier.

In loopback mode the status read reflects the control bits instead of the pins. The request-to-send and terminal-ready outputs are forced inactive. Pin activity raises no change flags.

A single `any_delta` line reports that at least one change flag is set. The interrupt logic of the UART uses it.

Top module: `mdm_ctrl_status`

## Requirements
- R1: After reset the control read gives 0x08: only the auxiliary output 2 bit is set. The output `out2_o` is 1 and the other three outputs are 0. `any_delta` is 0. A status read gives 0xB0: carrier, data-set-ready and clear-to-send are high, and every change flag is clear.
- R2: A control write stores `ctrl_wr_data[4:0]`, and the control read returns those bits with bits 7:5 read as zero. The bit meanings are bit0 terminal-ready (DTR), bit1 request-to-send (RTS), bit2 auxiliary output 1, bit3 auxiliary output 2, bit4 loopback. The four output pins take their new values on the edge that performs the write.
- R3: The status byte places the synchronised input levels at bit7 carrier detect, bit6 ring, bit5 data-set-ready and bit4 clear-to-send. A pin change reaches the upper half of the status byte, and any change flag it raises, on the third rising edge after the change.
- R4: Change flags sit at bit0 for clear-to-send, bit1 for data-set-ready and bit3 for carrier detect. Each flag is set by a change of its line in either direction and stays set until a status read.
- R5: Bit2 is set only when the ring line falls from 1 to 0. A rising ring line leaves it unchanged.
- R6: A status read pulse makes `msr_rd_data` show the status byte as it was before the read, starting one cycle later. The same edge clears bits 3:0. A change detected on that same edge is kept.
- R7: With loopback set, a status read returns auxiliary output 2 as carrier detect, auxiliary output 1 as ring, DTR as data-set-ready and RTS as clear-to-send. Bits 3:0 of the returned byte are 0, and the read leaves pending change flags untouched.
- R8: With loopback set, `rts_o` and `dtr_o` are 0 and pin changes raise no change flag. The auxiliary outputs still follow their control bits. After loopback is left, the status shows the present pin levels and no flag for changes made during loopback.
- R9: `any_delta` is 1 exactly when at least one of the four change flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 5 | Control register write value |
| ctrl_rd_data | output | 8 | Control register read value |
| msr_rd_en | input | 1 | Status read strobe (clears change flags) |
| msr_rd_data | output | 8 | Status byte captured by the last read |
| cts_i | input | 1 | Clear-to-send input line (asynchronous) |
| dsr_i | input | 1 | Data-set-ready input line (asynchronous) |
| ri_i | input | 1 | Ring input line (asynchronous) |
| dcd_i | input | 1 | Carrier detect input line (asynchronous) |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Terminal-ready output |
| out1_o | output | 1 | Auxiliary output 1 |
| out2_o | output | 1 | Auxiliary output 2 |
| any_delta | output | 1 | At least one change flag is set |

## Verification
The hardest case to reach is a pin change whose detection lands on the same edge as a status read, together with the entry and exit of loopback while flags are pending. Fixed directed steps rarely line these events up.

The bench therefore follows its directed steps with a long stream of random pin toggles, random reads and random control writes, some of them with loopback set. A reference model tracks the pin history, the flags and the read value, and compares all outputs on every clock. This lets such collisions occur at many different phases.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  // Line order inside a status nibble: {carrier, ring, set_ready, clear_to_send}
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  localparam int CTRL_W      = 5;
  localparam int BIT_DTR     = 0;
  localparam int BIT_RTS     = 1;
  localparam int BIT_OUT1    = 2;
  localparam int BIT_OUT2    = 3;
  localparam int BIT_LOOP    = 4;

  localparam logic [CTRL_W-1:0] CTRL_RST  = 5'b01000;
  localparam mdm_lines_t        LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= RST_VAL;
        else     chain_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= RST_VAL;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              out1_o,
  output logic              out2_o
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb ctrl_d = wr_en ? wr_data : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      rts_o  <= 1'b0;
      dtr_o  <= 1'b0;
      out1_o <= CTRL_RST[BIT_OUT1];
      out2_o <= CTRL_RST[BIT_OUT2];
    end else begin
      ctrl_q <= ctrl_d;
      rts_o  <= ctrl_d[BIT_RTS] & ~ctrl_d[BIT_LOOP];
      dtr_o  <= ctrl_d[BIT_DTR] & ~ctrl_d[BIT_LOOP];
      out1_o <= ctrl_d[BIT_OUT1];
      out2_o <= ctrl_d[BIT_OUT2];
    end
  end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mdm_lines_t        lines_sync,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic [3:0]        delta_q,
  output logic              any_delta
);
  mdm_lines_t prev_q;
  mdm_lines_t changed;
  mdm_lines_t loop_view;
  logic [3:0] new_delta;
  logic [3:0] delta_d;
  logic       loop_on;

  assign loop_on = ctrl[BIT_LOOP];
  assign changed = prev_q ^ lines_sync;

  // Flag layout: bit3 carrier, bit2 ring trailing edge, bit1 set_ready, bit0 clear_to_send
  always_comb begin
    new_delta = '0;
    if (!loop_on) begin
      new_delta[3] = changed.dcd;
      new_delta[2] = prev_q.ri & ~lines_sync.ri;
      new_delta[1] = changed.dsr;
      new_delta[0] = changed.cts;
    end
  end

  always_comb begin
    loop_view.dcd = ctrl[BIT_OUT2];
    loop_view.ri  = ctrl[BIT_OUT1];
    loop_view.dsr = ctrl[BIT_DTR];
    loop_view.cts = ctrl[BIT_RTS];
  end

  always_comb begin
    delta_d = ((rd_en && !loop_on) ? 4'b0000 : delta_q) | new_delta;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= LINES_RST;
      delta_q <= '0;
      rd_data <= {LINES_RST, 4'b0000};
    end else begin
      prev_q  <= lines_sync;
      delta_q <= delta_d;
      if (rd_en) begin
        rd_data <= loop_on ? {loop_view, 4'b0000} : {prev_q, delta_q};
      end
    end
  end

  assign any_delta = |delta_q;
endmodule

// File: rtl/mdm_ctrl_status.sv
module mdm_ctrl_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr_en,
  input  logic [4:0] ctrl_wr_data,
  output logic [7:0] ctrl_rd_data,
  input  logic       msr_rd_en,
  output logic [7:0] msr_rd_data,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       any_delta
);
  localparam int LINE_N = $bits(mdm_lines_t);

  logic [CTRL_W-1:0] ctrl_q;
  logic [3:0]        delta_q;
  mdm_lines_t        pins_raw;
  logic [LINE_N-1:0] pins_sync;

  assign pins_raw = '{dcd: dcd_i, ri: ri_i, dsr: dsr_i, cts: cts_i};

  mdm_sync #(
    .WIDTH  (LINE_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINES_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pins_raw),
    .dout(pins_sync)
  );

  mdm_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (ctrl_wr_en),
    .wr_data(ctrl_wr_data),
    .ctrl_q (ctrl_q),
    .rts_o  (rts_o),
    .dtr_o  (dtr_o),
    .out1_o (out1_o),
    .out2_o (out2_o)
  );

  mdm_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .lines_sync(pins_sync),
    .ctrl      (ctrl_q),
    .rd_en     (msr_rd_en),
    .rd_data   (msr_rd_data),
    .delta_q   (delta_q),
    .any_delta (any_delta)
  );

  assign ctrl_rd_data = {{(8-CTRL_W){1'b0}}, ctrl_q};
endmodule

// File: rtl/mdm_ctrl_status_chk.sv
module mdm_ctrl_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_wr_en,
  input logic [4:0] ctrl_wr_data,
  input logic [7:0] ctrl_rd_data,
  input logic       msr_rd_en,
  input logic [7:0] msr_rd_data,
  input logic       rts_o,
  input logic       dtr_o,
  input logic       out2_o,
  input logic       any_delta
);
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(any_delta) && !$past(msr_rd_en) |-> any_delta); // R4

  AST_READ_SHOWS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $past(msr_rd_en) && !$past(ctrl_rd_data[4]) && $past(any_delta) |-> msr_rd_data[3:0] != 4'h0); // R6

  AST_LOOP_READ_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(msr_rd_en) && $past(ctrl_rd_data[4]) |-> msr_rd_data[3:0] == 4'h0); // R7

  AST_LOOP_OUTS_LOW: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd_data[4] |-> !rts_o && !dtr_o); // R8

  AST_OUT2_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_wr_en) |-> out2_o == $past(ctrl_wr_data[3])); // R2
endmodule

bind mdm_ctrl_status mdm_ctrl_status_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .ctrl_wr_en  (ctrl_wr_en),
  .ctrl_wr_data(ctrl_wr_data),
  .ctrl_rd_data(ctrl_rd_data),
  .msr_rd_en   (msr_rd_en),
  .msr_rd_data (msr_rd_data),
  .rts_o       (rts_o),
  .dtr_o       (dtr_o),
  .out2_o      (out2_o),
  .any_delta   (any_delta)
);

// File: tb/mdm_ctrl_status_tb_top.sv
module mdm_ctrl_status_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_wr_en = 1'b0;
  logic [4:0] ctrl_wr_data = '0;
  logic [7:0] ctrl_rd_data;
  logic msr_rd_en = 1'b0;
  logic [7:0] msr_rd_data;
  logic cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
  logic rts_o, dtr_o, out1_o, out2_o, any_delta;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mdm_ctrl_status dut_i (.*);

  // Reference model: pin history and flags, line order {dcd, ri, dsr, cts}
  logic [3:0] m_hist1, m_hist2, m_seen;
  logic [3:0] m_flags;
  logic [4:0] m_ctrl;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    logic [3:0] pins, fresh;
    logic       lp;
    cycles++;
    pins = {dcd_i, ri_i, dsr_i, cts_i};
    if (rst) begin
      m_hist1 = 4'b1011; m_hist2 = 4'b1011; m_seen = 4'b1011;
      m_flags = 4'b0; m_ctrl = 5'b01000; m_rd = 8'hB0;
    end else begin
      lp = m_ctrl[4];
      fresh = 4'b0;
      if (!lp) begin
        fresh[3] = m_seen[3] != m_hist2[3];
        fresh[2] = m_seen[2] && !m_hist2[2];
        fresh[1] = m_seen[1] != m_hist2[1];
        fresh[0] = m_seen[0] != m_hist2[0];
      end
      if (msr_rd_en) begin
        if (lp) m_rd = {m_ctrl[3], m_ctrl[2], m_ctrl[0], m_ctrl[1], 4'b0};
        else    m_rd = {m_seen, m_flags};
        if (!lp) m_flags = 4'b0;
      end
      m_flags = m_flags | fresh;
      m_seen  = m_hist2;
      m_hist2 = m_hist1;
      m_hist1 = pins;
      if (ctrl_wr_en) m_ctrl = ctrl_wr_data;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 ctrl", ctrl_rd_data, {3'b0, m_ctrl});
      chk("R2 out", {4'b0, rts_o, dtr_o, out1_o, out2_o},
          {4'b0, m_ctrl[1] & ~m_ctrl[4], m_ctrl[0] & ~m_ctrl[4], m_ctrl[2], m_ctrl[3]});
      chk("R6 rd", msr_rd_data, m_rd);
      chk("R9 any", {7'b0, any_delta}, {7'b0, |m_flags});
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] v);
    ctrl_wr_en = 1'b1; ctrl_wr_data = v;
    @(negedge clk);
    ctrl_wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    msr_rd_en = 1'b1;
    @(negedge clk);
    msr_rd_en = 1'b0;
    v = msr_rd_data;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 ctrl", ctrl_rd_data, 8'h08);
    chk("R1 outs", {4'b0, rts_o, dtr_o, out1_o, out2_o}, 8'h01);
    chk("R1 any", {7'b0, any_delta}, 8'h00);
    rd(v); chk("R1 msr", v, 8'hB0);
    // R3/R4 clear-to-send falls: visible after third edge
    cts_i = 1'b0;
    tick(2); chk("R3 not yet", {7'b0, any_delta}, 8'h00);
    tick(1); chk("R3 arrived", {7'b0, any_delta}, 8'h01);
    rd(v); chk("R4 cts flag", v, 8'hA1);
    rd(v); chk("R6 cleared", v, 8'hA0);
    // R5 ring rise then fall
    ri_i = 1'b1; tick(4);
    rd(v); chk("R5 ring rise", v, 8'hE0);
    ri_i = 1'b0; tick(4);
    rd(v); chk("R5 ring fall", v, 8'hA4);
    // R4 two lines, and stickiness
    dcd_i = 1'b0; dsr_i = 1'b0; tick(4);
    rd(v); chk("R4 dcd dsr", v, 8'h0A);
    dsr_i = 1'b1; tick(4); dsr_i = 1'b0; tick(4);
    rd(v); chk("R4 sticky", v, 8'h02);
    // R2 write keeps low five bits
    wr(5'h03);
    chk("R2 rts dtr", {4'b0, rts_o, dtr_o, out1_o, out2_o}, 8'h0C);
    // R7/R8 loopback
    wr(5'h1F);
    chk("R8 outs", {4'b0, rts_o, dtr_o, out1_o, out2_o}, 8'h03);
    chk("R2 ctrl", ctrl_rd_data, 8'h1F);
    rd(v); chk("R7 loop all", v, 8'hF0);
    cts_i = 1'b1; tick(5);
    chk("R8 no flag", {7'b0, any_delta}, 8'h00);
    wr(5'h15);
    rd(v); chk("R7 map", v, 8'h60);
    wr(5'h03);
    rd(v); chk("R8 after loop", v, 8'h10);
    // R6 random stream: collisions of reads with detections
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0) cts_i = ~cts_i;
      if (r[5:3] == 3'd0) dsr_i = ~dsr_i;
      if (r[8:6] == 3'd0) ri_i  = ~ri_i;
      if (r[11:9] == 3'd0) dcd_i = ~dcd_i;
      msr_rd_en = (r[14:12] == 3'd0);
      ctrl_wr_en = (r[20:15] == 6'd0);
      ctrl_wr_data = r[25:21];
      @(negedge clk);
    end
    msr_rd_en = 1'b0; ctrl_wr_en = 1'b0;
    tick(2);
    finish_run();
  end
endmodule